// File: doc/BRIEF.md
# Raster to Block-Order Pixel Reorder Buffer

This block takes a stream of 8-bit pixels in raster scan order and sends the same pixels out again in block order. Pixels are stored line by line. When eight complete lines, which make one band, are held, the band is read out one 8x8 tile at a time, moving from the left edge of the image to the right. Inside each tile the pixels leave in a nested quadrant order. Each run of 4 tokens is a 2x2 square, each run of 16 is a 4x4 square, and each run of 64 is the whole tile. A downstream stage can therefore combine neighbours at every scale just by counting tokens.

Storage is split into two band-sized halves. The writer fills one half while the reader empties the other, and each side moves to the opposite half when it finishes a band. Input and output use valid/ready handshakes. A start-of-frame flag travels with the first pixel of each frame and puts the write position back to line 0, column 0. The image width is a parameter, with a default of 352. The height only has to be a multiple of eight, because the last band of a frame is handled like every other band.

Top module: `raster_to_block_reorder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `out_valid` stays 0 until all 8*IMG_W pixels of a band have been accepted, even when only one pixel of the band is still missing.
- R3: Inside each 2x2 square the pixels leave in this order: top-left, top-right, bottom-left, bottom-right.
- R4: Inside a tile, output token index i (0..63) carries the pixel at column x = {i[4], i[2], i[0]} and row y = {i[5], i[3], i[1]} of that tile. The sixteen 2x2 squares therefore form a nested quadrant order.
- R5: The tiles of a band leave from left to right. Tile t covers columns 8t to 8t+7.
- R6: While the previous band is still waiting to be read, a second band can be accepted with no stall.
- R7: When both halves hold unread bands, `in_ready` is 0. A pixel offered in that state is not taken and does not change the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R9: A pixel accepted with `in_sof` = 1 is written as line 0, column 0 of the current half. Any partly written band is discarded.
- R10: Once every stored band has been read, `out_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | PIX_W | Input pixel, raster order |
| in_ready | output | 1 | Buffer can take a pixel |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | PIX_W | Output pixel, block order |
| out_ready | input | 1 | Downstream takes the pixel |

## Verification
The hardest state to reach from the ports is both halves full with an unread band waiting, while the writer is also being pushed. The bench reaches it by holding `out_ready` low across two full bands, then offering one more pixel and checking that it is refused. Releasing the output under a stop-start ready pattern then drains both bands in order. The second hard case is a frame restart in the middle of a band. The bench writes a few lines of unrelated pixels, then starts a frame, and checks that only the clean band comes out.

// File: rtl/blkord_pkg.sv
package blkord_pkg;
  localparam int TILE = 8;
  localparam int TILE_PIX = TILE * TILE;

  // Token index inside a tile -> {row[2:0], col[2:0]}, nested quadrant order
  function automatic logic [5:0] tile_pos(input logic [5:0] i);
    logic [2:0] x;
    logic [2:0] y;
    x = {i[4], i[2], i[0]};
    y = {i[5], i[3], i[1]};
    return {y, x};
  endfunction
endpackage

// File: rtl/blkord_pp_ram.sv
module blkord_pp_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 5632,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/blkord_wr_ctrl.sv
module blkord_wr_ctrl
  import blkord_pkg::*;
#(
  parameter int IMG_W = 352,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [1:0]    bank_full,
  output logic          in_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          wbank,
  output logic          band_done
);
  localparam int CW = $clog2(IMG_W);
  localparam int BAND = TILE * IMG_W;
  localparam logic [AW-1:0] BAND_A = AW'(BAND);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);

  logic [CW-1:0] wcol, cur_col;
  logic [2:0]    wrow, cur_row;
  logic          at_end;

  assign in_ready = !bank_full[wbank];
  assign we       = in_valid && in_ready;
  assign cur_col  = in_sof ? '0 : wcol;
  assign cur_row  = in_sof ? '0 : wrow;
  assign at_end   = (cur_row == 3'd7) && (cur_col == COL_LAST);
  assign band_done = we && at_end;
  assign waddr = (wbank ? BAND_A : '0) + AW'(cur_row) * AW'(IMG_W) + AW'(cur_col);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcol  <= '0;
      wrow  <= '0;
      wbank <= 1'b0;
    end else if (we) begin
      if (cur_col == COL_LAST) begin
        wcol <= '0;
        wrow <= cur_row + 3'd1;
        if (at_end) wbank <= ~wbank;
      end else begin
        wcol <= cur_col + CW'(1);
        wrow <= cur_row;
      end
    end
  end

  // R9
  sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sof) |=> (wrow == 3'd0 && wcol == CW'(1)));
endmodule

// File: rtl/blkord_rd_ctrl.sv
module blkord_rd_ctrl
  import blkord_pkg::*;
#(
  parameter int IMG_W = 352,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_ready,
  input  logic [1:0]    bank_full,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          rbank,
  output logic          band_done,
  output logic          out_valid
);
  localparam int NBLK = IMG_W / TILE;
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int BAND = TILE * IMG_W;
  localparam logic [AW-1:0] BAND_A = AW'(BAND);
  localparam logic [BW-1:0] BLK_LAST = BW'(NBLK - 1);

  logic [BW-1:0] blk;
  logic [5:0]    idx;
  logic [5:0]    pos;

  assign pos = tile_pos(idx);
  assign re  = bank_full[rbank] && (!out_valid || out_ready);
  assign band_done = re && (idx == 6'd63) && (blk == BLK_LAST);
  assign raddr = (rbank ? BAND_A : '0) + AW'(pos[5:3]) * AW'(IMG_W)
               + AW'({blk, pos[2:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      blk       <= '0;
      idx       <= '0;
      rbank     <= 1'b0;
      out_valid <= 1'b0;
    end else if (re) begin
      out_valid <= 1'b1;
      idx <= idx + 6'd1;
      if (idx == 6'd63) begin
        if (blk == BLK_LAST) begin
          blk   <= '0;
          rbank <= ~rbank;
        end else begin
          blk <= blk + BW'(1);
        end
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  tile_step_chk: assert property (@(posedge clk) disable iff (rst)
    (re && idx == 6'd63 && blk != BLK_LAST) |=> (blk == $past(blk) + BW'(1) && idx == 6'd0));
endmodule

// File: rtl/raster_to_block_reorder.sv
module raster_to_block_reorder
  import blkord_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int IMG_W = 352
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sof,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  input  logic             out_ready
);
  localparam int DEPTH = 2 * TILE * IMG_W;
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    full;
  logic          we, re, wbank, rbank, wr_done, rd_done;
  logic [AW-1:0] waddr, raddr;

  blkord_wr_ctrl #(.IMG_W(IMG_W), .AW(AW)) wr_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .bank_full(full), .in_ready(in_ready), .we(we), .waddr(waddr),
    .wbank(wbank), .band_done(wr_done)
  );

  blkord_rd_ctrl #(.IMG_W(IMG_W), .AW(AW)) rd_i (
    .clk(clk), .rst(rst), .out_ready(out_ready), .bank_full(full),
    .re(re), .raddr(raddr), .rbank(rbank), .band_done(rd_done),
    .out_valid(out_valid)
  );

  blkord_pp_ram #(.DW(PIX_W), .DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
    .re(re), .raddr(raddr), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 2'b00;
    end else begin
      if (wr_done) full[wbank] <= 1'b1;
      if (rd_done) full[rbank] <= 1'b0;
    end
  end

  // R7
  stall_both_full_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (full == 2'b11));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  band_before_out_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(full) != 2'b00));

  // R10
  idle_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    (full == 2'b00 && out_ready) |=> !out_valid);
endmodule

// File: tb/raster_to_block_reorder_tb_top.sv
`timescale 1ns/1ps
module raster_to_block_reorder_tb_top;
  localparam int W = 16;
  localparam int BANDPIX = 8 * W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_sof = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0, rdy_mode = 0, cyc = 0, out_cnt = 0;
  bit finished = 0;
  logic [7:0] expq [$];
  bit prev_stall = 0;
  logic [7:0] prev_data = '0;

  always #2.5 clk = ~clk;

  raster_to_block_reorder #(.PIX_W(8), .IMG_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_sof(in_sof), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output ready pattern: 0 = always, 1 = stop-start, 2 = held low
  always @(posedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // output monitor: order (R3, R4, R5), hold (R8), spurious output (R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8 hold", int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R10 unexpected output", int'(out_data), -1);
        end else begin
          automatic logic [7:0] e = expq.pop_front();
          automatic int i = out_cnt % 64;
          automatic string tag = (i % 4 != 0) ? "R3 2x2 order" :
                                 (i % 16 != 0) ? "R4 quadrant order" : "R5 tile order";
          chk(out_data == e, tag, int'(out_data), int'(e));
          out_cnt++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic logic [7:0] pix(input int seed, input int r, input int c);
    return 8'((seed + r * W + c) & 8'hff);
  endfunction

  task automatic push_band(input int seed);
    for (int k = 0; k < BANDPIX; k++) begin
      automatic int i = k % 64;
      automatic int t = k / 64;
      automatic int x = (i & 1) | (((i >> 2) & 1) << 1) | (((i >> 4) & 1) << 2);
      automatic int y = ((i >> 1) & 1) | (((i >> 3) & 1) << 1) | (((i >> 5) & 1) << 2);
      expq.push_back(pix(seed, y, t * 8 + x));
    end
  endtask

  // entered and left at posedge + 1
  task automatic send_px(input logic [7:0] v, input bit sof, output int stalls);
    stalls = 0;
    in_valid = 1'b1; in_data = v; in_sof = sof;
    @(negedge clk);
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_band(input int seed, input bit sof, input int npix, output int stalls);
    int st;
    stalls = 0;
    for (int k = 0; k < npix; k++) begin
      send_px(pix(seed, k / W, k % W), sof && k == 0, st);
      stalls += st;
    end
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (expq.size() != 0 && n < 5000) begin @(posedge clk); n++; end
    repeat (3) @(posedge clk);
    #1;
    chk(expq.size() == 0, {tag, " all tokens out"}, expq.size(), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle after drain", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_threshold;
    int st;
    rdy_mode = 0;
    push_band(10);
    send_band(10, 1, BANDPIX - 1, st);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R2 no output with one pixel missing", int'(out_valid), 0);
    @(posedge clk); #1;
    send_px(pix(10, 7, W - 1), 1'b0, st);
    wait_drain("R2");
  endtask

  task automatic t_pingpong;
    int st0, st1;
    rdy_mode = 2;
    push_band(50);
    push_band(90);
    @(posedge clk); #1;
    send_band(50, 1, BANDPIX, st0);
    send_band(90, 0, BANDPIX, st1);
    chk(st1 == 0, "R6 second band without stall", st1, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 in_ready low with both halves full", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R6 first band offered", int'(out_valid), 1);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (6) @(negedge clk);
    chk(in_ready == 1'b0, "R7 extra pixel refused", int'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    rdy_mode = 1;
    wait_drain("R7");
    rdy_mode = 0;
  endtask

  task automatic t_sof_resync;
    int st;
    rdy_mode = 0;
    @(posedge clk); #1;
    send_band(200, 0, 3 * W + 5, st);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 partial band not emitted", int'(out_valid), 0);
    push_band(130);
    @(posedge clk); #1;
    send_band(130, 1, BANDPIX, st);
    wait_drain("R9");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    @(posedge clk); #1;
    t_threshold();
    t_pingpong();
    t_sof_resync();
    finish_run();
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", expq.size(), 0);
    finish_run();
  end
endmodule